// File: doc/BRIEF.md
# Partitioned Saturating Media Adder

This block adds or subtracts two 64-bit words that hold several small integers side by side. At run time the carry path is cut into independent lanes of 8, 16 or 32 bits. Each lane computes its own sum or difference, treating its operands as either two's-complement or unsigned numbers. A lane whose true result does not fit in the lane width either wraps around or is pinned to the nearest value that the lane can hold. A per-byte flag vector reports which lanes went out of range.

Operands and controls are presented together with `in_valid`. The result and flags are captured into output registers on that clock edge. `out_valid` marks the cycle in which they first appear. The outputs hold their values until the next accepted operation. Typical uses are pixel and audio-sample arithmetic, where pinning a value at its limit is preferred to wrapping.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_mode` selects the lane width: 2'b00 gives eight 8-bit lanes, 2'b01 gives four 16-bit lanes, and 2'b10 or 2'b11 gives two 32-bit lanes. Lane k occupies bits [k*w+w-1 : k*w], where w is the lane width.
- R2: No carry or borrow passes from one lane into the next. Inside a lane, carries do pass between byte positions.
- R3: With `sat_en`=0 and `sub_en`=0, each lane holds (a + b) mod 2^w.
- R4: With `sub_en`=1, each lane computes a - b, formed as a plus the bitwise inverse of b plus one. With `sat_en`=0 the lane holds (a - b) mod 2^w.
- R5: With `signed_en`=1 and an add, a lane overflows when both operands have the same sign and the lane result has the other sign. Operands of opposite sign never overflow.
- R6: With `signed_en`=1 and a subtract, a lane overflows only when the operand signs differ and the result sign differs from the sign of a.
- R7: With `signed_en`=0, a lane overflows on a carry out of its top bit during an add, and on a borrow (a < b) during a subtract.
- R8: With `sat_en`=1 and `signed_en`=1, an overflowing lane gives 2^(w-1)-1 when the true result is too large and -2^(w-1) when it is too small.
- R9: With `sat_en`=1 and `signed_en`=0, an overflowing lane gives all ones for an add and zero for a subtract.
- R10: `lane_ovf` bit i belongs to byte i of the word. Every byte of an overflowing lane has its bit set, whatever the value of `sat_en`.
- R11: On a rising edge with `in_valid`=1, `result` and `lane_ovf` take the values for the presented operands, and `out_valid` is 1 for the following cycle. Back-to-back operations keep `out_valid` at 1. On an edge with `in_valid`=0, `out_valid` becomes 0 and `result` and `lane_ovf` keep their values.
- R12: While `rst_n` is low, `out_valid`, `result` and `lane_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| op_a | input | 64 | First operand (minuend for subtract) |
| op_b | input | 64 | Second operand (subtrahend for subtract) |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| signed_en | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| lane_mode | input | 2 | Lane width select (see R1) |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Registered lane results |
| lane_ovf | output | 8 | Registered overflow flag per byte position |

## Verification
The hardest case is when one lane clamps while the lane next to it produces a carry at its top bit. In the same cycle, that carry must be dropped at the boundary, must not disturb the clamped lane, and must not be mistaken for that lane's overflow. The byte sweep causes this by holding all of op_a at one byte value and giving each lane of op_b a different value. In every vector some lanes saturate, some wrap with a carry out, and some stay in range. A second case is a new operation being captured in the same cycle that the previous result is being read. This happens throughout the sweep, which keeps `in_valid` high for consecutive vectors. Each lane is judged separately, against an integer model that computes the true sum or difference and then clamps or wraps it.

// File: rtl/simd_sat_pkg.sv
`timescale 1ns/1ps
package simd_sat_pkg;

    typedef enum logic [1:0] {
        LM_W8  = 2'b00,
        LM_W16 = 2'b01,
        LM_W32 = 2'b10,
        LM_W32X = 2'b11
    } lane_mode_e;

    // Lane span in units minus one; lanes are 1, 2 or 4 units wide.
    function automatic logic [1:0] span_minus_one(lane_mode_e m);
        case (m)
            LM_W8:   return 2'd0;
            LM_W16:  return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/simd_seg_add.sv
`timescale 1ns/1ps
module simd_seg_add #(
    parameter int UNIT_W = 8
) (
    input  logic [UNIT_W-1:0] a,
    input  logic [UNIT_W-1:0] bx,
    input  logic              cin,
    output logic [UNIT_W-1:0] sum,
    output logic              cout
);
    assign {cout, sum} = {1'b0, a} + {1'b0, bx} + {{UNIT_W{1'b0}}, cin};
endmodule

// File: rtl/simd_carry_chain.sv
`timescale 1ns/1ps
module simd_carry_chain #(
    parameter int UNIT_W = 8,
    parameter int UNITS  = 8,
    parameter int IDX_W  = $clog2(UNITS),
    parameter int DATA_W = UNIT_W * UNITS
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] bx,
    input  logic              sub,
    input  logic [IDX_W-1:0]  span_m1,
    output logic [DATA_W-1:0] sum,
    output logic [UNITS-1:0]  cout
);
    logic [UNITS-1:0] cin;

    for (genvar i = 0; i < UNITS; i++) begin : g_unit
        if (i == 0) begin : g_first
            assign cin[i] = sub;
        end else begin : g_rest
            // A unit that begins a lane takes the lane carry-in, not its neighbour's carry.
            assign cin[i] = ((IDX_W'(i) & span_m1) == '0) ? sub : cout[i-1];
        end
        simd_seg_add #(.UNIT_W(UNIT_W)) u_seg (
            .a    (a[i*UNIT_W +: UNIT_W]),
            .bx   (bx[i*UNIT_W +: UNIT_W]),
            .cin  (cin[i]),
            .sum  (sum[i*UNIT_W +: UNIT_W]),
            .cout (cout[i])
        );
    end
endmodule

// File: rtl/simd_lane_clamp.sv
`timescale 1ns/1ps
module simd_lane_clamp #(
    parameter int UNIT_W = 8,
    parameter int UNITS  = 8,
    parameter int IDX_W  = $clog2(UNITS),
    parameter int DATA_W = UNIT_W * UNITS
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] bx,
    input  logic [DATA_W-1:0] sum,
    input  logic [UNITS-1:0]  cout,
    input  logic [IDX_W-1:0]  span_m1,
    input  logic              signed_en,
    input  logic              sub_en,
    input  logic              sat_en,
    output logic [DATA_W-1:0] res,
    output logic [UNITS-1:0]  flag
);
    localparam int MSB = UNIT_W - 1;

    // Overflow and direction evaluated as if each unit were the top of its lane.
    logic [UNITS-1:0] ovf_top;
    logic [UNITS-1:0] up_top;

    for (genvar i = 0; i < UNITS; i++) begin : g_top
        logic a_m, b_m, s_m;
        assign a_m = a[i*UNIT_W + MSB];
        assign b_m = bx[i*UNIT_W + MSB];
        assign s_m = sum[i*UNIT_W + MSB];
        assign ovf_top[i] = signed_en ? ((a_m == b_m) && (s_m != a_m)) : (cout[i] ^ sub_en);
        assign up_top[i]  = signed_en ? ~a_m : ~sub_en;
    end

    for (genvar i = 0; i < UNITS; i++) begin : g_out
        logic [IDX_W-1:0]  top_d;
        logic              is_top_d;
        logic              up_d;
        logic [UNIT_W-1:0] fill_d;

        always_comb begin
            top_d    = IDX_W'(i) | span_m1;
            is_top_d = (top_d == IDX_W'(i));
            up_d     = up_top[top_d];
            flag[i]  = ovf_top[top_d];
            if (signed_en && is_top_d) begin
                fill_d = up_d ? {1'b0, {MSB{1'b1}}} : {1'b1, {MSB{1'b0}}};
            end else begin
                fill_d = up_d ? {UNIT_W{1'b1}} : {UNIT_W{1'b0}};
            end
            res[i*UNIT_W +: UNIT_W] = (sat_en && flag[i]) ? fill_d : sum[i*UNIT_W +: UNIT_W];
        end
    end
endmodule

// File: rtl/simd_sat_adder.sv
`timescale 1ns/1ps
module simd_sat_adder
    import simd_sat_pkg::*;
#(
    parameter int UNIT_W = 8,
    parameter int UNITS  = 8,
    localparam int DATA_W = UNIT_W * UNITS,
    localparam int IDX_W  = $clog2(UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              sub_en,
    input  logic              signed_en,
    input  logic [1:0]        lane_mode,
    input  logic              sat_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [UNITS-1:0]  lane_ovf
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [UNITS-1:0]  ovf;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0]  span_m1;
    logic [DATA_W-1:0] bx;
    logic [DATA_W-1:0] raw_sum;
    logic [UNITS-1:0]  unit_cout;
    logic [DATA_W-1:0] lane_res;
    logic [UNITS-1:0]  lane_flag;

    assign span_m1 = IDX_W'(span_minus_one(lane_mode_e'(lane_mode)));
    assign bx      = op_b ^ {DATA_W{sub_en}};

    simd_carry_chain #(.UNIT_W(UNIT_W), .UNITS(UNITS)) u_chain (
        .a       (op_a),
        .bx      (bx),
        .sub     (sub_en),
        .span_m1 (span_m1),
        .sum     (raw_sum),
        .cout    (unit_cout)
    );

    simd_lane_clamp #(.UNIT_W(UNIT_W), .UNITS(UNITS)) u_clamp (
        .a         (op_a),
        .bx        (bx),
        .sum       (raw_sum),
        .cout      (unit_cout),
        .span_m1   (span_m1),
        .signed_en (signed_en),
        .sub_en    (sub_en),
        .sat_en    (sat_en),
        .res       (lane_res),
        .flag      (lane_flag)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = lane_res;
            state_d.ovf = lane_flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
    assign lane_ovf  = state_q.ovf;
endmodule

// File: rtl/simd_sat_adder_chk.sv
`timescale 1ns/1ps
module simd_sat_adder_chk #(
    parameter int UNIT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [UNIT_W-1:0] a_lo,
    input logic [UNIT_W-1:0] b_lo,
    input logic              sub_en,
    input logic              signed_en,
    input logic [1:0]        lane_mode,
    input logic              sat_en,
    input logic              out_valid,
    input logic [UNIT_W-1:0] res_lo,
    input logic [3:0]        flags_lo
);
    logic [UNIT_W-1:0] wrap_ref;
    assign wrap_ref = sub_en ? (a_lo - b_lo) : (a_lo + b_lo);

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_lo) && $stable(flags_lo)));

    // R10
    flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lane_mode) == 2'b01) |-> (flags_lo[0] == flags_lo[1]));

    // R10
    flag_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lane_mode[1])) |-> (flags_lo == 4'h0 || flags_lo == 4'hF));

    // R9
    usat_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(sat_en && !signed_en && !sub_en && lane_mode == 2'b00) && flags_lo[0])
        |-> (res_lo == {UNIT_W{1'b1}}));

    // R3
    wrap_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!sat_en && lane_mode == 2'b00)) |-> (res_lo == $past(wrap_ref)));
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.UNIT_W(UNIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_lo      (op_a[UNIT_W-1:0]),
    .b_lo      (op_b[UNIT_W-1:0]),
    .sub_en    (sub_en),
    .signed_en (signed_en),
    .lane_mode (lane_mode),
    .sat_en    (sat_en),
    .out_valid (out_valid),
    .res_lo    (result[UNIT_W-1:0]),
    .flags_lo  (lane_ovf[3:0])
);

// File: tb/simd_sat_adder_test.sv
`timescale 1ns/1ps
module simd_sat_adder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        sub_en = 1'b0;
    logic        signed_en = 1'b0;
    logic [1:0]  lane_mode = 2'b00;
    logic        sat_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  lane_ovf;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    simd_sat_adder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sub_en(sub_en), .signed_en(signed_en), .lane_mode(lane_mode), .sat_en(sat_en),
        .out_valid(out_valid), .result(result), .lane_ovf(lane_ovf)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<190000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Integer reference for one lane of width w.
    function automatic void lane_ref(input longint unsigned a, input longint unsigned b, input int w,
                                     input bit sub, input bit sgn, input bit sat,
                                     output longint unsigned r, output bit ov);
        longint one, sa, sb, x, lo, hi;
        one = 1;
        sa = longint'(a);
        sb = longint'(b);
        if (sgn) begin
            if (a[w-1]) sa = sa - (one << w);
            if (b[w-1]) sb = sb - (one << w);
            lo = -(one << (w-1));
            hi = (one << (w-1)) - 1;
        end else begin
            lo = 0;
            hi = (one << w) - 1;
        end
        x  = sub ? (sa - sb) : (sa + sb);
        ov = (x < lo) || (x > hi);
        if (sat && ov) x = (x > hi) ? hi : lo;
        r = longint'(x) & ((one << w) - 1);
    endfunction

    function automatic void word_ref(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                                     input bit sub, input bit sgn, input bit sat,
                                     output logic [63:0] r, output logic [7:0] f);
        int w, n;
        longint unsigned mask, lr;
        bit lo;
        w = (m == 2'b00) ? 8 : (m == 2'b01) ? 16 : 32;
        n = 64 / w;
        mask = (longint'(1) << w) - 1;
        r = '0;
        f = '0;
        for (int l = 0; l < n; l++) begin
            lane_ref((a >> (l*w)) & mask, (b >> (l*w)) & mask, w, sub, sgn, sat, lr, lo);
            r = r | (64'(lr) << (l*w));
            for (int k = 0; k < w/8; k++) f[l*(w/8)+k] = lo;
        end
    endfunction

    logic [63:0] last_res;
    logic [7:0]  last_flag;

    task automatic run_vec(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                           input bit sub, input bit sgn, input bit sat,
                           input string rtag, input string ftag);
        logic [63:0] er;
        logic [7:0]  ef;
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; lane_mode = m;
        sub_en = sub; signed_en = sgn; sat_en = sat;
        word_ref(a, b, m, sub, sgn, sat, er, ef);
        @(posedge clk);
        #1;
        check(rtag, result, er);
        check(ftag, {56'd0, lane_ovf}, {56'd0, ef});
        last_res = er;
        last_flag = ef;
    endtask

    function automatic string res_tag(input bit sub, input bit sgn, input bit sat);
        if (sat) return sgn ? "R8" : "R9";
        return sub ? "R4" : "R3";
    endfunction

    function automatic string flag_tag(input bit sub, input bit sgn);
        if (!sgn) return "R7";
        return sub ? "R6" : "R5";
    endfunction

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 out_valid", {63'd0, out_valid}, 64'd0);
        check("R12 result", result, 64'd0);
        check("R12 lane_ovf", {56'd0, lane_ovf}, 64'd0);
        rst_n = 1'b1;

        // R2: carries stop at lane edges but cross bytes inside a lane
        run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 0, 0, 0, "R2 byte lanes", "R2 flags");
        check("R2 byte lanes exact", result, 64'h0);
        run_vec(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b01, 0, 0, 0, "R2 half lanes", "R2 flags");
        check("R2 half lanes exact", result, 64'h0100_0100_0100_0100);
        run_vec(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 0, 0, 0, "R2 word lanes", "R2 flags");
        check("R2 word lanes exact", result, 64'h0);
        check("R10 word flags", {56'd0, lane_ovf}, 64'h0F);

        // Byte-lane sweep: every pair of byte values under all control combinations
        for (int c = 0; c < 8; c++) begin
            for (int av = 0; av < 256; av++) begin
                for (int bg = 0; bg < 32; bg++) begin
                    logic [63:0] bw;
                    for (int l = 0; l < 8; l++) bw[l*8 +: 8] = 8'(bg*8 + l);
                    run_vec({8{8'(av)}}, bw, 2'b00, c[0], c[1], c[2],
                            res_tag(c[0], c[1], c[2]), flag_tag(c[0], c[1]));
                end
            end
        end

        // Wider lanes: corner words plus pseudo-random words, all modes including 2'b11
        for (int m = 1; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                run_vec(64'h7FFF_FFFF_8000_7FFF, 64'h0000_0001_FFFF_0001, 2'(m), c[0], c[1], c[2], "R1 corner", "R10 corner");
                run_vec(64'h8000_0000_0000_8000, 64'h7FFF_FFFF_0001_8000, 2'(m), c[0], c[1], c[2], "R1 corner", "R10 corner");
                for (int k = 0; k < 200; k++) begin
                    run_vec({$urandom, $urandom}, {$urandom, $urandom}, 2'(m), c[0], c[1], c[2], "R1 random", "R10 random");
                end
            end
        end

        // R11: idle edges hold the outputs and drop out_valid
        @(negedge clk);
        in_valid = 1'b0;
        op_a = 64'h1234_5678_9ABC_DEF0;
        op_b = 64'h0FED_CBA9_8765_4321;
        @(posedge clk); #1;
        check("R11 out_valid drops", {63'd0, out_valid}, 64'd0);
        check("R11 result held", result, last_res);
        check("R11 flags held", {56'd0, lane_ovf}, {56'd0, last_flag});
        @(posedge clk); #1;
        check("R11 result still held", result, last_res);

        // R11: single-cycle pulse
        run_vec(64'h0000_0000_0000_0005, 64'h0000_0000_0000_0003, 2'b00, 1, 0, 0, "R11 pulse", "R11 pulse flags");
        check("R11 out_valid high", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        check("R11 out_valid one cycle", {63'd0, out_valid}, 64'd0);
        check("R11 pulse result kept", result, 64'h2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule